// File: doc/BRIEF.md
# Direct CV Access Engine

This engine carries out direct-addressing service instructions against an internal store of 1024 byte-wide configuration variables (CVs). An upstream entry controller hands it a packet that has already been framed and qualified: a one-cycle execute pulse together with three bytes. These are the command byte, the low address byte and the data byte. The engine decodes the instruction, reads the addressed CV and then carries out a byte verify, a byte write, a single-bit verify or a single-bit write.

A verify that matches, and every completed write, drives an acknowledge-load output for a fixed number of clocks. The default length is 6 ms at 50 MHz. Before a write is acknowledged, a configurable busy interval models the non-volatile update delay.

Writing the short-address CV has two side effects, whether the write is a byte write or a bit write. The engine clears the consist CV and clears the extended-address flag in the configuration CV. While the engine is working on an instruction, it ignores any new execute pulse.

Top module: `cv_direct_engine`

## Requirements
- R1: The CV index is 10 bits wide. Its top two bits are command bits [1:0] and its low eight bits are the address byte. CV number n sits at index n-1, so index 0 is CV 1 and index 1023 is CV 1024.
- R2: An execute pulse is accepted only in the following cases, and is otherwise ignored with no acknowledge and no store change:
  - command bits [7:4] are 0111, and
  - the operation field, command bits [3:2], is 01, 10 or 11. The value 00 is not used.
- R3: Operation 01 is a byte verify. The acknowledge rises two clocks after the accepting edge only if the stored byte equals the data byte. On a mismatch no acknowledge is given.
- R4: Operation 11 is a byte write. It stores the data byte. For an index other than 0, the acknowledge rises BUSY_CYCLES+2 clocks after the accepting edge.
- R5: Operation 10 is bit manipulation, and its data byte has the form 111KDBBB:
  - BBB is the bit position and D is the bit value.
  - K=1 writes the bit and keeps the other bits. Its acknowledge timing is the same as a byte write.
  - K=0 verifies the bit, with the acknowledge timing of a byte verify.
  - A data byte whose top three bits are not 111 is ignored.
- R6: Every acknowledge stays high for exactly ACK_CYCLES clocks. The default of 300000 gives 6 ms at 50 MHz.
- R7: Any write to CV 1 (index 0) also clears CV 19 (index 18) to 0 and clears bit 5 of CV 29 (index 28). For such a write the acknowledge rises BUSY_CYCLES+5 clocks after the accepting edge.
- R8: An execute pulse that arrives while the engine is processing, busy or acknowledging is ignored. The first pulse accepted is one on the clock after the acknowledge falls, or, when no acknowledge is given, on the third clock after acceptance.
- R9: After reset the acknowledge is low and the engine is idle. Every CV holds 0 from power-up, and reset does not alter the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | One-cycle pulse: the three bytes hold a qualified instruction |
| cmd_i | input | 8 | Command byte: 0111, operation field, index bits [9:8] |
| idx_lo_i | input | 8 | Index bits [7:0] |
| data_i | input | 8 | Data byte, or the bit-manipulation descriptor |
| ack_o | output | 1 | Acknowledge-load request |

## Verification
The bench writes distinct values at indices 0x3FF, 0x100 and 0x0FF and then verifies each of them. This shows that the two high index bits are decoded separately from the low byte. Byte verifies with matching and non-matching data separate a genuine comparison from an acknowledge that is always given.

Bit verifies and bit writes at positions 0, 1 and 7, followed by byte verifies, show that only the addressed bit is touched. The command and descriptor encodings that are reserved or malformed are shown to leave the store as it was.

Writes to CV 1, both byte and bit, are followed by verifies of CV 19 and CV 29. These expose the side effects and the three extra clocks of latency. A write issued in the middle of an acknowledge checks that the engine ignores it.

// File: rtl/cvd_pkg.sv
package cvd_pkg;
  localparam int CV_AW     = 10;
  localparam int CV_DW     = 8;
  localparam int CV_DEPTH  = 1 << CV_AW;
  localparam int CONSIST_IX = 18;   // CV 19
  localparam int CONFIG_IX  = 28;   // CV 29
  localparam int EXT_ADDR_BIT = 5;

  typedef enum logic [1:0] {
    K_BYTE_VFY,
    K_BYTE_WR,
    K_BIT_VFY,
    K_BIT_WR
  } op_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CMP,
    ST_CLR_CONS,
    ST_RD_CFG,
    ST_WR_CFG,
    ST_BUSY,
    ST_ACK
  } eng_state_t;
endpackage

// File: rtl/cvd_decode.sv
module cvd_decode
  import cvd_pkg::*;
(
  input  logic [7:0]       cmd,
  input  logic [7:0]       idx_lo,
  input  logic [7:0]       data,
  output logic             ok,
  output op_kind_t         kind,
  output logic [CV_AW-1:0] idx,
  output logic [CV_DW-1:0] val,
  output logic [2:0]       bpos,
  output logic             bval
);
  logic [1:0] opf;

  always_comb begin
    opf  = cmd[3:2];
    idx  = {cmd[1:0], idx_lo};
    val  = data;
    bpos = data[2:0];
    bval = data[3];
    kind = K_BYTE_VFY;
    ok   = 1'b0;
    if (cmd[7:4] == 4'b0111) begin
      case (opf)
        2'b01: begin kind = K_BYTE_VFY; ok = 1'b1; end
        2'b11: begin kind = K_BYTE_WR;  ok = 1'b1; end
        2'b10: begin
          kind = data[4] ? K_BIT_WR : K_BIT_VFY;
          ok   = (data[7:5] == 3'b111);
        end
        default: ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cvd_store.sv
module cvd_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cv_direct_engine.sv
module cv_direct_engine
  import cvd_pkg::*;
#(
  parameter int BUSY_CYCLES = 2500,
  parameter int ACK_CYCLES  = 300000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       exec_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] idx_lo_i,
  input  logic [7:0] data_i,
  output logic       ack_o
);
  localparam int MAXC = (ACK_CYCLES > BUSY_CYCLES) ? ACK_CYCLES : BUSY_CYCLES;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CV_AW-1:0] CONS_A = CV_AW'(CONSIST_IX);
  localparam logic [CV_AW-1:0] CFG_A  = CV_AW'(CONFIG_IX);
  localparam logic [CV_DW-1:0] EXT_M  = CV_DW'(1) << EXT_ADDR_BIT;

  logic             dec_ok, dec_bval;
  op_kind_t         dec_kind;
  logic [CV_AW-1:0] dec_idx;
  logic [CV_DW-1:0] dec_val;
  logic [2:0]       dec_bpos;

  cvd_decode u_dec (
    .cmd(cmd_i), .idx_lo(idx_lo_i), .data(data_i),
    .ok(dec_ok), .kind(dec_kind), .idx(dec_idx), .val(dec_val),
    .bpos(dec_bpos), .bval(dec_bval)
  );

  eng_state_t       st;
  op_kind_t         lat_kind;
  logic [CV_AW-1:0] lat_idx;
  logic [CV_DW-1:0] lat_val;
  logic [2:0]       lat_bpos;
  logic             lat_bval;
  logic [CW-1:0]    cnt;
  logic             ack_q;

  logic             m_we;
  logic [CV_AW-1:0] m_addr;
  logic [CV_DW-1:0] m_wdata, m_rdata, bit_mask, merged;
  logic             is_match, is_write;

  cvd_store #(.AW(CV_AW), .DW(CV_DW)) u_store (
    .clk(clk), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata)
  );

  always_comb begin
    bit_mask = CV_DW'(1) << lat_bpos;
    merged   = lat_bval ? (m_rdata | bit_mask) : (m_rdata & ~bit_mask);
    is_write = (lat_kind == K_BYTE_WR) || (lat_kind == K_BIT_WR);
    is_match = (lat_kind == K_BIT_VFY) ? (m_rdata[lat_bpos] == lat_bval)
                                       : (m_rdata == lat_val);
    m_we    = 1'b0;
    m_addr  = lat_idx;
    m_wdata = '0;
    case (st)
      ST_CMP: if (is_write) begin
        m_we    = 1'b1;
        m_wdata = (lat_kind == K_BIT_WR) ? merged : lat_val;
      end
      ST_CLR_CONS: begin m_we = 1'b1; m_addr = CONS_A; end
      ST_RD_CFG:   m_addr = CFG_A;
      ST_WR_CFG: begin
        m_we    = 1'b1;
        m_addr  = CFG_A;
        m_wdata = m_rdata & ~EXT_M;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ack_q    <= 1'b0;
      cnt      <= '0;
      lat_kind <= K_BYTE_VFY;
      lat_idx  <= '0;
      lat_val  <= '0;
      lat_bpos <= '0;
      lat_bval <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (exec_i && dec_ok) begin
          lat_kind <= dec_kind;
          lat_idx  <= dec_idx;
          lat_val  <= dec_val;
          lat_bpos <= dec_bpos;
          lat_bval <= dec_bval;
          st       <= ST_RD;
        end
        ST_RD: st <= ST_CMP;
        ST_CMP: begin
          if (is_write) begin
            if (lat_idx == '0) st <= ST_CLR_CONS;
            else begin
              st  <= ST_BUSY;
              cnt <= CW'(BUSY_CYCLES - 1);
            end
          end else if (is_match) begin
            st    <= ST_ACK;
            cnt   <= CW'(ACK_CYCLES - 1);
            ack_q <= 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_CLR_CONS: st <= ST_RD_CFG;
        ST_RD_CFG:   st <= ST_WR_CFG;
        ST_WR_CFG: begin
          st  <= ST_BUSY;
          cnt <= CW'(BUSY_CYCLES - 1);
        end
        ST_BUSY: begin
          if (cnt == '0) begin
            st    <= ST_ACK;
            cnt   <= CW'(ACK_CYCLES - 1);
            ack_q <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_ACK: begin
          if (cnt == '0) begin
            st    <= ST_IDLE;
            ack_q <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ack_o = ack_q;

  // Length of the current acknowledge, kept only for the checks below.
  int ack_run;
  always_ff @(posedge clk) begin
    if (rst || !ack_q) ack_run <= 0;
    else ack_run <= ack_run + 1;
  end

  assert_ack_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_q) |-> (ack_run == ACK_CYCLES));

  assert_cv1_side_R7: assert property (@(posedge clk) disable iff (rst)
    (m_we && m_addr == '0) |=> (m_we && m_addr == CONS_A && m_wdata == '0));

  assert_no_ack_mismatch_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CMP && !is_write && !is_match) |=> !ack_q);

  assert_ignore_in_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && exec_i) |=> (st == ST_ACK || st == ST_IDLE));

  assert_ack_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> ($past(st) == ST_BUSY || $past(st) == ST_CMP));
endmodule

// File: tb/cv_direct_engine_tb_top.sv
module cv_direct_engine_tb_top;
  localparam int BUSY = 4;
  localparam int ACKN = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exec_i = 1'b0;
  logic [7:0] cmd_i = '0, idx_lo_i = '0, data_i = '0;
  logic ack_o;

  cv_direct_engine #(.BUSY_CYCLES(BUSY), .ACK_CYCLES(ACKN)) dut_i (
    .clk(clk), .rst(rst), .exec_i(exec_i), .cmd_i(cmd_i),
    .idx_lo_i(idx_lo_i), .data_i(data_i), .ack_o(ack_o)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, idle_at = 0, ack_s = 0, ack_e = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [1024];
  string pend_tag = "R9", cur_tag = "R9";

  initial for (int i = 0; i < 1024; i++) ref_mem[i] = 8'h00;

  // Behavioural reference: decides at each accepting edge when ack is due.
  always @(posedge clk) begin
    int ix, lat;
    logic [7:0] d, c;
    bit vfy, hit;
    cyc = cyc + 1;
    if (rst) begin
      idle_at = cyc + 1; ack_s = 0; ack_e = 0;
    end else if (exec_i && cyc >= idle_at) begin
      c = cmd_i; d = data_i;
      ix = {c[1:0], idx_lo_i};
      cur_tag = pend_tag;
      if (c[7:4] != 4'b0111 || c[3:2] == 2'b00 ||
          (c[3:2] == 2'b10 && d[7:5] != 3'b111)) begin
        idle_at = cyc + 1;
      end else begin
        vfy = (c[3:2] == 2'b01) || (c[3:2] == 2'b10 && !d[4]);
        if (vfy) begin
          if (c[3:2] == 2'b01) hit = (ref_mem[ix] == d);
          else hit = (ref_mem[ix][d[2:0]] == d[3]);
          if (hit) begin
            ack_s = cyc + 2; ack_e = ack_s + ACKN; idle_at = ack_e + 1;
          end else idle_at = cyc + 3;
        end else begin
          if (c[3:2] == 2'b11) ref_mem[ix] = d;
          else ref_mem[ix][d[2:0]] = d[3];
          lat = 2 + BUSY;
          if (ix == 0) begin
            ref_mem[18] = 8'h00;
            ref_mem[28][5] = 1'b0;
            lat = 5 + BUSY;
          end
          ack_s = cyc + lat; ack_e = ack_s + ACKN; idle_at = ack_e + 1;
        end
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    logic expv;
    string tg;
    if (!rst && !done) begin
      expv = (cyc >= ack_s) && (cyc < ack_e);
      tg = (cyc == ack_e || cyc == ack_e - 1) ? "R6" : cur_tag;
      total++;
      if (ack_o !== expv) begin
        bad++;
        $display("FAIL %s cycle %0d: ack_o actual=%0b expected=%0b", tg, cyc, ack_o, expv);
      end
    end
  end

  task automatic send(input logic [7:0] c, input logic [7:0] lo,
                      input logic [7:0] d, input string tg, input bit wait_idle);
    if (wait_idle) while (cyc + 1 < idle_at) @(negedge clk);
    pend_tag = tg;
    cmd_i = c; idx_lo_i = lo; data_i = d; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  task automatic settle();
    while (cyc + 1 < idle_at) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (ack_o !== 1'b0) begin
      bad++;
      $display("FAIL R9 reset: ack_o actual=%0b expected=0", ack_o);
    end
    // R9 / R3: store starts at zero; match and mismatch
    send(8'h74, 8'h05, 8'h00, "R9", 1);
    send(8'h74, 8'h05, 8'h12, "R3", 1);
    // R4 / R1: writes at distinct high and low index bits
    send(8'h7F, 8'hFF, 8'hA5, "R4", 1);
    send(8'h7D, 8'h00, 8'h3C, "R4", 1);
    send(8'h7C, 8'hFF, 8'h66, "R4", 1);
    send(8'h77, 8'hFF, 8'hA5, "R1", 1);
    send(8'h75, 8'h00, 8'h3C, "R1", 1);
    send(8'h74, 8'hFF, 8'h66, "R1", 1);
    send(8'h74, 8'hFF, 8'hA5, "R1", 1);
    // R5: bit verify, bit write, malformed descriptor
    send(8'h7B, 8'hFF, 8'b1110_1000, "R5", 1);
    send(8'h7B, 8'hFF, 8'b1110_0111, "R5", 1);
    send(8'h7B, 8'hFF, 8'b1111_1001, "R5", 1);
    send(8'h7B, 8'hFF, 8'b1111_0111, "R5", 1);
    send(8'h77, 8'hFF, 8'h27, "R5", 1);
    send(8'h7B, 8'hFF, 8'b0101_1000, "R5", 1);
    send(8'h77, 8'hFF, 8'h27, "R5", 1);
    // R7: CV 1 side effects via byte and bit writes
    send(8'h7C, 8'h12, 8'h55, "R7", 1);
    send(8'h7C, 8'h1C, 8'hFF, "R7", 1);
    send(8'h7C, 8'h00, 8'h03, "R7", 1);
    send(8'h74, 8'h12, 8'h00, "R7", 1);
    send(8'h74, 8'h1C, 8'hDF, "R7", 1);
    send(8'h74, 8'h00, 8'h03, "R7", 1);
    send(8'h7C, 8'h12, 8'h44, "R7", 1);
    send(8'h7C, 8'h1C, 8'h20, "R7", 1);
    send(8'h78, 8'h00, 8'b1111_1010, "R7", 1);
    send(8'h74, 8'h1C, 8'h00, "R7", 1);
    send(8'h74, 8'h12, 8'h00, "R7", 1);
    send(8'h74, 8'h00, 8'h07, "R7", 1);
    // R2: reserved operation and wrong top nibble
    send(8'h70, 8'hF0, 8'h99, "R2", 1);
    send(8'h5C, 8'hF0, 8'h99, "R2", 1);
    send(8'h74, 8'hF0, 8'h00, "R2", 1);
    // R8: write during busy and during ack is ignored
    send(8'h7C, 8'h07, 8'h11, "R8", 1);
    repeat (3) @(negedge clk);
    send(8'h7C, 8'h07, 8'h22, "R8", 0);
    repeat (BUSY + 4) @(negedge clk);
    send(8'h7C, 8'h07, 8'h33, "R8", 0);
    send(8'h74, 8'h07, 8'h11, "R8", 1);
    send(8'h74, 8'h07, 8'h22, "R8", 1);
    send(8'h74, 8'h07, 8'h33, "R8", 1);
    settle();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule